// File: doc/BRIEF.md
# Address Translation Buffer with Page-Table Walker

This block turns 32-bit virtual addresses into 30-bit physical addresses. It keeps recent translations in a small, fully associative buffer of eight entries. All tags are compared in parallel against the virtual page number, which is bits 31..12 of the address. The low 12 bits pass through unchanged. When the buffer has no translation, a hardware walker reads one 32-bit page-table entry over a single-outstanding memory port. The entry's word address is the page-table base plus four times the virtual page number.

A valid entry is installed in the buffer and the request completes. An invalid entry returns a fault response and installs nothing. The walker keeps the entry's reference and dirty bits current in memory. It sets the reference bit on first use and the dirty bit on the first write, and writes the updated word back before it responds. Replacement takes an empty slot first and otherwise the least recently used slot. A flush input empties the buffer in one cycle.

Requests and responses are valid/ready streams. A request transfers when `req_valid` and `req_ready` are both high at a rising edge. A response is offered on `rsp_valid` and is held, with its payload stable, until `rsp_ready` is high. The block accepts one request at a time. `req_ready` falls while a walk runs, while flush is high, and while an earlier response is still waiting.

The memory port works as follows:
- A command is held on `mem_req` until `mem_gnt` is seen at a rising edge.
- Read data returns later with a one-cycle `mem_rvalid` pulse.
- Writes have no reply.

Control pins (`flush`, `ptbr`) are plain levels. `ptbr` is sampled when a walk starts.

Top module: `xlat_tlb`

## Requirements
- R1: The response address carries the page's 18-bit physical page number in bits 29..12 and the request's address bits 11..0 in bits 11..0.
- R2: A request transfers only when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is low while a walk is running, while `flush` is high, and while `rsp_valid` is high with `rsp_ready` low. A pending response keeps `rsp_valid`, `rsp_paddr` and `rsp_fault` unchanged until `rsp_ready` is high.
- R3: A request that hits needs no status update when it is a read, or a write to an entry already marked dirty. Such a request raises `rsp_valid` in the cycle after it transfers, with `rsp_fault` low, and makes no memory access.
- R4: On a miss, the entry is read from word address `ptbr + {vpn, 2'b00}` with `mem_we` low. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_gnt`.
- R5: Page-table entry layout: bit 31 valid, bit 30 reference, bit 29 dirty, bits 17..0 physical page number. If the valid bit is clear, the response has `rsp_fault` high and `rsp_paddr` zero. Nothing is installed, any buffered copy of that page is dropped, and a repeat request walks again.
- R6: After a valid entry is read, the walker writes it back to the same address with the reference bit set if the reference bit was clear, or if the request is a write and the dirty bit was clear. For a write, the dirty bit is also set in the write-back. The write-back happens before the response. If neither condition holds, no write occurs.
- R7: A write that hits an entry whose dirty bit is clear walks the table again: one read, then one write-back that sets the dirty bit. The same slot is then reloaded with the dirty bit set, so the next write to that page hits without memory traffic.
- R8: A refill uses the lowest-numbered empty slot. If the buffer is full, it replaces the least recently used slot, where every hit and every refill counts as a use of its slot.
- R9: A high `flush` at a rising edge empties the buffer. A walk that sees flush still delivers its response but installs nothing.
- R10: After reset the buffer is empty, `rsp_valid` and `mem_req` are low and `req_ready` is high.
- R11: At most one buffer entry ever matches a given page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the buffer |
| ptbr | input | 30 | Physical base address of the page table |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 30 | Translated address, zero on fault |
| rsp_fault | output | 1 | Page was not present |
| mem_req | output | 1 | Memory command pending |
| mem_gnt | input | 1 | Memory accepts the command |
| mem_we | output | 1 | Command is a write |
| mem_addr | output | 30 | Page-table entry address |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Page-table entry read |

## Verification
Several properties are checked on every cycle:
- No page ever matches two entries.
- The recency ages always form a permutation.
- A flush leaves the buffer empty.
- Offered responses and memory commands hold steady under back-pressure.
- Only entries with their valid bit set are installed.
- A write-back always carries the reference bit.

Some behaviour only the bench scenarios can show. These include which slot is evicted after a known sequence of uses, and the page-table address and traffic count of each walk. They also include the fault path leaving no entry behind, a clean write forcing a second walk, and a flush during a walk suppressing the install.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Page-table entry word layout (field positions are decoded by the walker)
  localparam int PTE_W = 32;
  localparam int PTE_V = 31;
  localparam int PTE_R = 30;
  localparam int PTE_D = 29;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_PTE,
    ST_WAIT_PTE,
    ST_WRITE_PTE,
    ST_REFILL
  } walk_st_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_dirty,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [ENTRIES];
  logic               dirty_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (tag_q[i] == lk_vpn);
  end

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_idx = IDX_W'(i);
    end
  end

  assign lk_hit    = |match;
  assign lk_ppn    = ppn_q[lk_idx];
  assign lk_dirty  = dirty_q[lk_idx];
  assign valid_vec = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else begin
      if (inv_en) vld_q[inv_idx] <= 1'b0;
      if (wr_en)  vld_q[wr_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx]   <= wr_vpn;
      ppn_q[wr_idx]   <= wr_ppn;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R11
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R9
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  // age 0 = most recent, ENTRIES-1 = least recent; ages stay a permutation
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age_q[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (touch_idx == IDX_W'(i))   age_q[i] <= '0;
        else if (age_q[i] < ref_age)  age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_vec[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
      end
    end
  end

  for (genvar v = 0; v < ENTRIES; v++) begin : g_perm
    logic [ENTRIES-1:0] eq;
    for (genvar i = 0; i < ENTRIES; i++) begin : g_eq
      assign eq[i] = (age_q[i] == IDX_W'(v));
    end
    AST_AGE_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(eq) == 1); // R8
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int PA_W  = 30,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic             start_write,
  input  logic             start_resident,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [PA_W-1:0]  ptbr,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  input  logic [IDX_W-1:0] victim_idx,
  output logic             inst_en,
  output logic [IDX_W-1:0] inst_idx,
  output logic [VPN_W-1:0] inst_vpn,
  output logic [PPN_W-1:0] inst_ppn,
  output logic             inst_dirty,
  output logic             inv_en,
  output logic [IDX_W-1:0] inv_idx,
  output logic             done,
  output logic             done_fault,
  output logic [PPN_W-1:0] done_ppn
);
  localparam int PAD_W = PA_W - VPN_W - 2;

  walk_st_e         st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic             wr_q, res_q, kill_q;
  logic [IDX_W-1:0] idx_q;
  logic [PA_W-1:0]  addr_q;
  logic [PTE_W-1:0] pte_q, upd_pte;
  logic             rd_ok, fault_now;

  always_comb begin
    upd_pte        = mem_rdata;
    upd_pte[PTE_R] = 1'b1;
    if (wr_q) upd_pte[PTE_D] = 1'b1;
  end

  assign rd_ok     = (st_q == ST_WAIT_PTE) && mem_rvalid;
  assign fault_now = rd_ok && !mem_rdata[PTE_V];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (start) st_d = ST_READ_PTE;
      ST_READ_PTE:  if (mem_gnt) st_d = ST_WAIT_PTE;
      ST_WAIT_PTE: begin
        if (mem_rvalid) begin
          if (!mem_rdata[PTE_V])        st_d = ST_IDLE;
          else if (upd_pte != mem_rdata) st_d = ST_WRITE_PTE;
          else                           st_d = ST_REFILL;
        end
      end
      ST_WRITE_PTE: if (mem_gnt) st_d = ST_REFILL;
      ST_REFILL:    st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      vpn_q  <= '0;
      wr_q   <= 1'b0;
      res_q  <= 1'b0;
      idx_q  <= '0;
      kill_q <= 1'b0;
      addr_q <= '0;
      pte_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        vpn_q  <= start_vpn;
        wr_q   <= start_write;
        res_q  <= start_resident;
        idx_q  <= start_idx;
        kill_q <= 1'b0;
        addr_q <= ptbr + {{PAD_W{1'b0}}, start_vpn, 2'b00};
      end else if (flush && st_q != ST_IDLE) begin
        kill_q <= 1'b1;
      end
      if (rd_ok) pte_q <= upd_pte;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign mem_req    = (st_q == ST_READ_PTE) || (st_q == ST_WRITE_PTE);
  assign mem_we     = (st_q == ST_WRITE_PTE);
  assign mem_addr   = addr_q;
  assign mem_wdata  = pte_q;

  assign inst_en    = (st_q == ST_REFILL) && !kill_q && !flush;
  assign inst_idx   = res_q ? idx_q : victim_idx;
  assign inst_vpn   = vpn_q;
  assign inst_ppn   = pte_q[PPN_W-1:0];
  assign inst_dirty = pte_q[PTE_D];

  assign inv_en     = fault_now && res_q && !kill_q && !flush;
  assign inv_idx    = idx_q;

  assign done       = fault_now || (st_q == ST_REFILL);
  assign done_fault = fault_now;
  assign done_ppn   = pte_q[PPN_W-1:0];

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_VALID_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |-> pte_q[PTE_V]); // R5
  AST_WB_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[PTE_R] && (!wr_q || mem_wdata[PTE_D]))); // R6
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PA_W-1:0]  ptbr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]     req_vpn;
  logic                 lk_hit, lk_dirty;
  logic [IDX_W-1:0]     lk_idx, victim_idx;
  logic [PPN_W-1:0]     lk_ppn;
  logic [ENTRIES-1:0]   valid_vec;
  logic                 busy, req_fire, need_walk, hit_fire;
  logic                 inst_en, inst_dirty, inv_en;
  logic [IDX_W-1:0]     inst_idx, inv_idx;
  logic [VPN_W-1:0]     inst_vpn;
  logic [PPN_W-1:0]     inst_ppn, done_ppn;
  logic                 done, done_fault;
  logic [PAGE_BITS-1:0] ofs_q;

  assign req_vpn   = req_vaddr[VA_W-1:PAGE_BITS];
  assign req_ready = !busy && !flush && (!rsp_valid || rsp_ready);
  assign req_fire  = req_valid && req_ready;
  assign need_walk = !lk_hit || (req_write && !lk_dirty);
  assign hit_fire  = req_fire && !need_walk;

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_vpn    (req_vpn),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .lk_ppn    (lk_ppn),
    .lk_dirty  (lk_dirty),
    .wr_en     (inst_en),
    .wr_idx    (inst_idx),
    .wr_vpn    (inst_vpn),
    .wr_ppn    (inst_ppn),
    .wr_dirty  (inst_dirty),
    .inv_en    (inv_en),
    .inv_idx   (inv_idx),
    .valid_vec (valid_vec)
  );

  xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (hit_fire || inst_en),
    .touch_idx  (hit_fire ? lk_idx : inst_idx),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx)
  );

  xlat_walker #(.PA_W(PA_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .start          (req_fire && need_walk),
    .start_vpn      (req_vpn),
    .start_write    (req_write),
    .start_resident (lk_hit),
    .start_idx      (lk_idx),
    .ptbr           (ptbr),
    .busy           (busy),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_gnt        (mem_gnt),
    .mem_rvalid     (mem_rvalid),
    .mem_rdata      (mem_rdata),
    .victim_idx     (victim_idx),
    .inst_en        (inst_en),
    .inst_idx       (inst_idx),
    .inst_vpn       (inst_vpn),
    .inst_ppn       (inst_ppn),
    .inst_dirty     (inst_dirty),
    .inv_en         (inv_en),
    .inv_idx        (inv_idx),
    .done           (done),
    .done_fault     (done_fault),
    .done_ppn       (done_ppn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      ofs_q     <= '0;
    end else begin
      if (req_fire) ofs_q <= req_vaddr[PAGE_BITS-1:0];
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (hit_fire) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= {lk_ppn, req_vaddr[PAGE_BITS-1:0]};
        rsp_fault <= 1'b0;
      end else if (done) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= done_fault ? '0 : {done_ppn, ofs_q};
        rsp_fault <= done_fault;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R2
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit && (!req_write || lk_dirty))
      |=> (rsp_valid && !rsp_fault && !mem_req)); // R3
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R2
endmodule

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
  localparam logic [29:0] PTBR = 30'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [29:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req, mem_we;
  logic        mem_gnt = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  xlat_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbr(PTBR),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, acc_cyc = 0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] pt [logic [29:0]];
  logic [29:0] rd_addr, last_rd;
  bit          rv_pend = 0;

  logic [29:0] q_pa[$];
  bit          q_flt[$];
  int          q_lat[$];
  string       q_tag[$];

  function automatic logic [29:0] pte_addr(logic [19:0] vpn);
    return PTBR + {8'h00, vpn, 2'b00};
  endfunction

  function automatic logic [31:0] pt_at(logic [29:0] a);
    return pt.exists(a) ? pt[a] : 32'h0;
  endfunction

  task automatic chk(string req, bit ok, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // memory model: grant one cycle after request, read data the cycle after grant
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 0; mem_rvalid = 0; rv_pend = 0;
    end else begin
      mem_rvalid = 0;
      if (rv_pend) begin
        mem_rvalid = 1; mem_rdata = pt_at(rd_addr); rv_pend = 0;
      end
      if (mem_gnt) mem_gnt = 0;
      else if (mem_req) begin
        mem_gnt = 1;
        if (mem_we) begin pt[mem_addr] = mem_wdata; n_wr++; end
        else begin rd_addr = mem_addr; last_rd = mem_addr; rv_pend = 1; n_rd++; end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_pa.size() == 0) begin
        chk("R2", 0, "unexpected response", rsp_paddr, 0);
      end else begin
        logic [29:0] epa; bit eflt; int elat; string etag;
        epa = q_pa.pop_front(); eflt = q_flt.pop_front();
        elat = q_lat.pop_front(); etag = q_tag.pop_front();
        chk(etag, rsp_paddr == epa, "paddr", rsp_paddr, epa);
        chk(etag, rsp_fault == eflt, "fault", rsp_fault, eflt);
        if (elat != 0) chk(etag, (cyc - acc_cyc) == elat, "latency", cyc - acc_cyc, elat);
      end
    end
  end

  task automatic issue(logic [31:0] va, bit wr, int lat, int erd, int ewr, int hold, string tag);
    logic [31:0] pte;
    int rd0, wr0;
    pte = pt_at(pte_addr(va[31:12]));
    q_pa.push_back(pte[31] ? {pte[17:0], va[11:0]} : 30'd0);
    q_flt.push_back(!pte[31]);
    q_lat.push_back(lat);
    q_tag.push_back(tag);
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    if (hold > 0) rsp_ready = 0;
    req_valid = 1; req_vaddr = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 0;
    if (hold > 0) begin
      while (!rsp_valid) @(negedge clk);
      for (int k = 0; k < hold; k++) begin
        chk("R2", rsp_valid && !req_ready, "held response / ready", {rsp_valid, req_ready}, 2'b10);
        @(negedge clk);
      end
      rsp_ready = 1;
    end
    while (q_pa.size() != 0) @(negedge clk);
    chk(tag, (n_rd - rd0) == erd, "table reads", n_rd - rd0, erd);
    chk(tag, (n_wr - wr0) == ewr, "table writes", n_wr - wr0, ewr);
    if (erd > 0) chk("R4", last_rd == pte_addr(va[31:12]), "entry address", last_rd, pte_addr(va[31:12]));
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    #0.1 chk("R9", !req_ready, "ready during flush", req_ready, 0);
    @(negedge clk); flush = 0;
  endtask

  function automatic logic [31:0] va_of(logic [19:0] vpn, logic [11:0] ofs);
    return {vpn, ofs};
  endfunction

  initial begin
    for (int v = 1; v <= 10; v++) pt[pte_addr(20'(v))] = {3'b100, 11'h0, 18'h2A000 + 18'(v * 37)};
    pt[pte_addr(20'h0000C)] = {3'b110, 11'h0, 18'h15555};
    pt[pte_addr(20'h00050)] = {3'b000, 11'h0, 18'h00123};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", req_ready == 1, "ready after reset", req_ready, 1);
    chk("R10", rsp_valid == 0, "rsp_valid after reset", rsp_valid, 0);
    chk("R10", mem_req == 0, "mem_req after reset", mem_req, 0);

    issue(va_of(20'h1, 12'hABC), 0, 0, 1, 1, 0, "R4");
    chk("R6", pt_at(pte_addr(20'h1))[30] == 1, "ref bit written", pt_at(pte_addr(20'h1)), 0);
    issue(va_of(20'h1, 12'h004), 0, 1, 0, 0, 0, "R3");
    issue(va_of(20'h1, 12'hFFF), 0, 1, 0, 0, 0, "R1");
    issue(va_of(20'h1, 12'h010), 1, 0, 1, 1, 0, "R7");
    chk("R7", pt_at(pte_addr(20'h1))[29] == 1, "dirty bit written", pt_at(pte_addr(20'h1)), 0);
    issue(va_of(20'h1, 12'h020), 1, 1, 0, 0, 0, "R7");   // same slot reused, R11 guarded
    issue(va_of(20'hC, 12'h333), 0, 0, 1, 0, 0, "R6");
    issue(va_of(20'h50, 12'h444), 0, 0, 1, 0, 0, "R5");
    issue(va_of(20'h50, 12'h444), 0, 0, 1, 0, 0, "R5");

    for (int v = 2; v <= 7; v++) issue(va_of(20'(v), 12'h100), 0, 0, 1, 1, 0, "R8");
    issue(va_of(20'h1, 12'h000), 0, 1, 0, 0, 0, "R8");
    issue(va_of(20'h8, 12'h008), 0, 0, 1, 1, 0, "R8");   // evicts page C
    issue(va_of(20'h1, 12'h000), 0, 1, 0, 0, 0, "R8");
    issue(va_of(20'hC, 12'h00C), 0, 0, 1, 0, 0, "R8");   // evicts page 2
    issue(va_of(20'h3, 12'h003), 0, 1, 0, 0, 0, "R8");
    issue(va_of(20'h2, 12'h002), 0, 0, 1, 0, 0, "R8");   // evicts page 4
    issue(va_of(20'h5, 12'h005), 0, 1, 0, 0, 0, "R8");

    issue(va_of(20'h3, 12'h777), 0, 0, 0, 0, 3, "R2");

    pulse_flush();
    issue(va_of(20'h1, 12'h111), 0, 0, 1, 0, 0, "R9");
    issue(va_of(20'h1, 12'h222), 1, 1, 0, 0, 0, "R7");

    fork
      issue(va_of(20'h9, 12'h999), 0, 0, 1, 1, 0, "R9");
      begin
        wait (mem_req == 1);
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
      end
    join
    issue(va_of(20'h9, 12'h998), 0, 0, 1, 0, 0, "R9");
    issue(va_of(20'h9, 12'h997), 0, 1, 0, 0, 0, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule